// File: doc/BRIEF.md
# Dual-Track Magnetic Stripe Receiver

This block takes the digital outputs of a two-track magnetic stripe read head and turns them into framed characters. Each track has three inputs: a bit strobe that pulses once per recorded bit, a data level that is valid around that strobe, and a card-present level. Both tracks run at the same time and do not depend on each other. Track 1 carries 7-bit characters (6 data bits and an odd parity bit). Track 2 carries 5-bit characters (4 data bits and an odd parity bit). Bits arrive least significant first.

After a card is inserted, a track first runs in hunt mode. A sliding window of one character width moves over the bit stream one bit at a time. The track locks only when the window holds the start code. Before that point it discards the run of null characters and any corrupted bits near the card edge. Once locked, the track cuts the stream into characters at fixed boundaries and gives a one-cycle ready pulse for each character. A parity fault sets a sticky status bit, and the character is still delivered. The interrupt output is high whenever any track gives a ready pulse or a sync pulse. A host uses that interrupt to fetch the characters.

Top module: `magstripe_dual_rx`

## Requirements
- R1: After a synchronous active-low reset, all ready, sync, locked, parity-status and interrupt outputs are 0.
- R2: While in hunt mode, a track gives no ready pulse. Leading null characters (track 1: 0x40, track 2: 0x10, sent LSB first) and stray bits do not make it lock.
- R3: On the strobe that completes the start code in the window, the track gives a sync pulse of exactly one cycle, and its locked output rises in that same cycle.
- R4: Once locked, every group of consecutive bits of character width gives one ready pulse. The character output holds the group with its first-received bit at bit 0.
- R5: A character whose total count of ones is even sets the track's parity status bit. That bit stays set until the card is removed. The faulty character is still delivered with its ready pulse.
- R6: When card-present is low, the track clears its lock, its parity status and any partly received character. Strobes that arrive while it is low have no effect.
- R7: The interrupt output is 1 exactly in the cycles where at least one of the two ready pulses or the two sync pulses is 1.
- R8: The two tracks are received at the same time with unrelated strobe timing. Each track's characters come out undisturbed by the other track.
- R9: The start codes are 0x45 for track 1 (6-bit data 0x05 with parity 1) and 0x0B for track 2 (4-bit data 0xB with parity 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trk1_strobe | input | 1 | Track 1 bit strobe, active high, asynchronous |
| trk1_data | input | 1 | Track 1 data level |
| trk1_present | input | 1 | Track 1 card-present level |
| trk2_strobe | input | 1 | Track 2 bit strobe, active high, asynchronous |
| trk2_data | input | 1 | Track 2 data level |
| trk2_present | input | 1 | Track 2 card-present level |
| trk1_char | output | 7 | Last framed track 1 character |
| trk1_ready | output | 1 | One-cycle pulse, new track 1 character |
| trk1_sync | output | 1 | One-cycle pulse, track 1 start code found |
| trk1_locked | output | 1 | Track 1 is framing characters |
| trk1_par_err | output | 1 | Sticky track 1 parity fault |
| trk2_char | output | 5 | Last framed track 2 character |
| trk2_ready | output | 1 | One-cycle pulse, new track 2 character |
| trk2_sync | output | 1 | One-cycle pulse, track 2 start code found |
| trk2_locked | output | 1 | Track 2 is framing characters |
| trk2_par_err | output | 1 | Sticky track 2 parity fault |
| irq | output | 1 | OR of both ready and both sync pulses |

## Verification
The stimulus sends runs of null characters followed by stray bits that overlap part of the start code. These runs must give no ready or sync pulse, which separates true start-code matching from early locking. Characters with correct parity and with wrong parity are sent to show that faulty data is still delivered while the status bit sticks. A partial character cut off by card removal, followed by strobes sent with no card present, shows whether state survives where it should not. Both tracks then stream at the same time with different bit timing, which exposes any coupling between them or any interrupt that does not match the pulses.

// File: rtl/magstripe_pkg.sv
// Package: shared types and helpers for the magnetic stripe receiver.
// Assumes characters carry odd parity over all their bits.
package magstripe_pkg;

    typedef enum logic {
        TRK_HUNT   = 1'b0,
        TRK_FRAMED = 1'b1
    } trk_mode_e;

    // True when the bit vector fails odd parity (even number of ones).
    function automatic logic parity_bad7(input logic [6:0] v, input int unsigned w);
        logic acc;
        acc = 1'b0;
        for (int i = 0; i < 7; i++) begin
            if (i < int'(w)) acc = acc ^ v[i];
        end
        return ~acc;
    endfunction

endpackage

// File: rtl/magstripe_in_sync.sv
// Module: brings one track's three asynchronous inputs into the clock
// domain and reports the rising edge of the bit strobe.
// Assumes each strobe level lasts at least one clock and that data is
// settled before the strobe rises (it is synchronised with equal depth).
module magstripe_in_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_in,
    input  logic data_in,
    input  logic present_in,
    output logic strobe_rise,
    output logic data_s,
    output logic present_s
);
    localparam int unsigned NSIG = 3;

    logic [NSIG-1:0] chain [STAGES];
    logic            strobe_last;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First flop of the synchroniser chain samples the raw pins.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[g] <= '0;
                    else        chain[g] <= {present_in, data_in, strobe_in};
                end
            end else begin : g_next
                // Later flops pass the vector one stage down the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[g] <= '0;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    // Delayed copy of the synchronised strobe for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_last <= 1'b0;
        else        strobe_last <= chain[STAGES-1][0];
    end

    assign strobe_rise = chain[STAGES-1][0] & ~strobe_last;
    assign data_s      = chain[STAGES-1][1];
    assign present_s   = chain[STAGES-1][2];

    // A detected edge can never repeat in the following cycle.
    assert_single_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_rise |=> !strobe_rise);

endmodule

// File: rtl/magstripe_track_rx.sv
// Module: one track's receiver. In hunt mode a window of one character
// width slides over the bits until it equals the start code; then bits
// are framed at fixed boundaries, LSB first, one ready pulse per char.
// Assumes bit_stb is a single-cycle pulse with bit_val valid alongside.
module magstripe_track_rx
    import magstripe_pkg::*;
#(
    parameter int unsigned     W     = 7,
    parameter logic [W-1:0]    START = 7'h45
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bit_stb,
    input  logic         bit_val,
    input  logic         present,
    output logic [W-1:0] char_o,
    output logic         ready_o,
    output logic         sync_o,
    output logic         locked_o,
    output logic         par_err_o
);
    localparam int unsigned CW   = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    trk_mode_e      mode;
    logic [W-1:0]   win;
    logic [W-1:0]   win_next;
    logic [CW-1:0]  cnt;
    logic [6:0]     par_vec;

    assign win_next = {bit_val, win[W-1:1]};
    assign locked_o = (mode == TRK_FRAMED);

    // Widen the completed character for the shared parity helper.
    always_comb begin
        par_vec = '0;
        par_vec[W-1:0] = win_next;
    end

    // Hunt/framing state machine, window shifter and character output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode      <= TRK_HUNT;
            win       <= '0;
            cnt       <= '0;
            char_o    <= '0;
            ready_o   <= 1'b0;
            sync_o    <= 1'b0;
            par_err_o <= 1'b0;
        end else begin
            ready_o <= 1'b0;
            sync_o  <= 1'b0;
            if (!present) begin
                mode      <= TRK_HUNT;
                win       <= '0;
                cnt       <= '0;
                par_err_o <= 1'b0;
            end else if (bit_stb) begin
                win <= win_next;
                if (mode == TRK_HUNT) begin
                    if (win_next == START) begin
                        mode   <= TRK_FRAMED;
                        sync_o <= 1'b1;
                        cnt    <= '0;
                    end
                end else if (cnt == LAST) begin
                    cnt     <= '0;
                    char_o  <= win_next;
                    ready_o <= 1'b1;
                    if (parity_bad7(par_vec, W)) par_err_o <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // Characters only come out of a track that stayed locked.
    assert_ready_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> locked_o);
    // The bit counter never passes the last position of a character.
    assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
    // Sync is a one-cycle pulse that coincides with the lock rising.
    assert_sync_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sync_o |=> !sync_o);
    assert_sync_lock_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sync_o |-> $rose(locked_o));
    // No lock and no parity status survive a card absence.
    assert_absent_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !present |=> (!locked_o && !par_err_o));
    // Parity status sticks while the card stays present.
    assert_par_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (par_err_o && present) |=> par_err_o);

endmodule

// File: rtl/magstripe_dual_rx.sv
// Module: top of the dual-track receiver. Two synchronisers feed two
// independent track receivers; the interrupt merges their pulses.
// Assumes strobes are slow next to clk (many clocks per bit).
module magstripe_dual_rx #(
    parameter int unsigned     T1_W        = 7,
    parameter int unsigned     T2_W        = 5,
    parameter logic [T1_W-1:0] T1_START    = 7'h45,
    parameter logic [T2_W-1:0] T2_START    = 5'h0B,
    parameter int unsigned     SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            trk1_strobe,
    input  logic            trk1_data,
    input  logic            trk1_present,
    input  logic            trk2_strobe,
    input  logic            trk2_data,
    input  logic            trk2_present,
    output logic [T1_W-1:0] trk1_char,
    output logic            trk1_ready,
    output logic            trk1_sync,
    output logic            trk1_locked,
    output logic            trk1_par_err,
    output logic [T2_W-1:0] trk2_char,
    output logic            trk2_ready,
    output logic            trk2_sync,
    output logic            trk2_locked,
    output logic            trk2_par_err,
    output logic            irq
);
    logic t1_rise, t1_dat, t1_pres;
    logic t2_rise, t2_dat, t2_pres;

    magstripe_in_sync #(.STAGES(SYNC_STAGES)) i_sync1 (
        .clk(clk), .rst_n(rst_n),
        .strobe_in(trk1_strobe), .data_in(trk1_data), .present_in(trk1_present),
        .strobe_rise(t1_rise), .data_s(t1_dat), .present_s(t1_pres)
    );

    magstripe_in_sync #(.STAGES(SYNC_STAGES)) i_sync2 (
        .clk(clk), .rst_n(rst_n),
        .strobe_in(trk2_strobe), .data_in(trk2_data), .present_in(trk2_present),
        .strobe_rise(t2_rise), .data_s(t2_dat), .present_s(t2_pres)
    );

    magstripe_track_rx #(.W(T1_W), .START(T1_START)) i_trk1 (
        .clk(clk), .rst_n(rst_n),
        .bit_stb(t1_rise), .bit_val(t1_dat), .present(t1_pres),
        .char_o(trk1_char), .ready_o(trk1_ready), .sync_o(trk1_sync),
        .locked_o(trk1_locked), .par_err_o(trk1_par_err)
    );

    magstripe_track_rx #(.W(T2_W), .START(T2_START)) i_trk2 (
        .clk(clk), .rst_n(rst_n),
        .bit_stb(t2_rise), .bit_val(t2_dat), .present(t2_pres),
        .char_o(trk2_char), .ready_o(trk2_ready), .sync_o(trk2_sync),
        .locked_o(trk2_locked), .par_err_o(trk2_par_err)
    );

    // Merged interrupt: any character or start-code event on either track.
    assign irq = trk1_ready | trk2_ready | trk1_sync | trk2_sync;

endmodule

// File: tb/test_magstripe_dual_rx.sv
// Bench: scoreboard style. Driver tasks push expected characters into
// per-track queues; a monitor pops and compares on each ready pulse.
module test_magstripe_dual_rx;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic s1 = 0, d1 = 0, p1 = 0, s2 = 0, d2 = 0, p2 = 0;
    logic [6:0] c1;
    logic [4:0] c2;
    logic r1, y1, l1, e1, r2, y2, l2, e2, irq;

    int n_checks = 0;
    int n_fail   = 0;
    int sync1_cnt = 0;
    int sync2_cnt = 0;
    bit done = 0;
    logic [6:0] q1 [$];
    logic [4:0] q2 [$];

    always #2 clk = ~clk;

    magstripe_dual_rx i_magstripe_dual_rx (
        .clk(clk), .rst_n(rst_n),
        .trk1_strobe(s1), .trk1_data(d1), .trk1_present(p1),
        .trk2_strobe(s2), .trk2_data(d2), .trk2_present(p2),
        .trk1_char(c1), .trk1_ready(r1), .trk1_sync(y1), .trk1_locked(l1), .trk1_par_err(e1),
        .trk2_char(c2), .trk2_ready(r2), .trk2_sync(y2), .trk2_locked(l2), .trk2_par_err(e2),
        .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] mk1(input logic [5:0] d);
        return {~^d, d};
    endfunction
    function automatic logic [4:0] mk2(input logic [3:0] d);
        return {~^d, d};
    endfunction

    task automatic send_bit(input int trk, input logic b);
        if (trk == 1) begin
            d1 = b;
            repeat (3) @(negedge clk);
            s1 = 1'b1;
            repeat (4) @(negedge clk);
            s1 = 1'b0;
            repeat (3) @(negedge clk);
        end else begin
            d2 = b;
            repeat (2) @(negedge clk);
            s2 = 1'b1;
            repeat (2) @(negedge clk);
            s2 = 1'b0;
            repeat (5) @(negedge clk);
        end
    endtask

    task automatic send_char(input int trk, input logic [6:0] v);
        int w;
        w = (trk == 1) ? 7 : 5;
        for (int i = 0; i < w; i++) send_bit(trk, v[i]);
    endtask

    // Monitor: compares each delivered character and checks the interrupt.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (r1) begin
                if (q1.size() == 0) chk(0, "R2/R4 trk1 unexpected ready", c1, 0);
                else begin
                    logic [6:0] e;
                    e = q1.pop_front();
                    chk(c1 == e, "R4 trk1 char", c1, e);
                end
            end
            if (r2) begin
                if (q2.size() == 0) chk(0, "R2/R4 trk2 unexpected ready", c2, 0);
                else begin
                    logic [4:0] e;
                    e = q2.pop_front();
                    chk(c2 == e, "R4 trk2 char", c2, e);
                end
            end
            if (y1) sync1_cnt++;
            if (y2) sync2_cnt++;
            if (irq !== (r1 | r2 | y1 | y2))
                chk(0, "R7 irq mismatch", irq, r1 | r2 | y1 | y2);
            else if (irq)
                chk(1, "R7 irq", irq, 1);
        end
    end

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk({r1, y1, l1, e1, r2, y2, l2, e2, irq} == 9'b0, "R1 reset outputs",
            {r1, y1, l1, e1, r2, y2, l2, e2, irq}, 0);

        // R2: nulls and stray bits do not lock track 1
        p1 = 1'b1;
        repeat (4) @(negedge clk);
        repeat (3) send_char(1, 7'h40);
        send_bit(1, 1); send_bit(1, 1); send_bit(1, 0);
        chk(l1 == 0, "R2 trk1 unlocked after nulls", l1, 0);
        chk(sync1_cnt == 0, "R2 trk1 no sync on nulls", sync1_cnt, 0);

        // R3 / R9: start code 0x45 locks track 1
        send_char(1, 7'h45);
        chk(l1 == 1, "R3 trk1 locked", l1, 1);
        chk(sync1_cnt == 1, "R3 R9 trk1 one sync", sync1_cnt, 1);

        // R4: framed characters, LSB first
        q1.push_back(mk1(6'h21)); send_char(1, mk1(6'h21));
        q1.push_back(mk1(6'h10)); send_char(1, mk1(6'h10));
        q1.push_back(mk1(6'h3F)); send_char(1, mk1(6'h3F));
        repeat (10) @(negedge clk);
        chk(q1.size() == 0, "R4 trk1 all chars delivered", q1.size(), 0);
        chk(e1 == 0, "R5 trk1 no parity fault on good chars", e1, 0);

        // R5: bad parity delivered, status sticky
        q1.push_back(7'h03); send_char(1, 7'h03);
        repeat (4) @(negedge clk);
        chk(e1 == 1, "R5 trk1 parity fault set", e1, 1);
        q1.push_back(mk1(6'h15)); send_char(1, mk1(6'h15));
        repeat (4) @(negedge clk);
        chk(e1 == 1, "R5 trk1 parity fault sticky", e1, 1);
        chk(q1.size() == 0, "R5 trk1 faulty char delivered", q1.size(), 0);

        // R6: card removal clears state; strobes while absent ignored
        send_bit(1, 1); send_bit(1, 0); send_bit(1, 1);
        p1 = 1'b0;
        repeat (6) @(negedge clk);
        chk(l1 == 0, "R6 trk1 unlocked on removal", l1, 0);
        chk(e1 == 0, "R6 trk1 parity status cleared", e1, 0);
        send_char(1, 7'h45);
        send_char(1, mk1(6'h2A));
        chk(l1 == 0, "R6 trk1 strobes ignored while absent", l1, 0);
        chk(sync1_cnt == 1, "R6 trk1 no sync while absent", sync1_cnt, 1);
        p1 = 1'b1;
        repeat (4) @(negedge clk);
        send_char(1, 7'h40);
        send_char(1, 7'h45);
        chk(l1 == 1, "R6 trk1 relocks after reinsertion", l1, 1);
        q1.push_back(mk1(6'h0C)); send_char(1, mk1(6'h0C));

        // R8 / R9: both tracks at once, unrelated timing
        p2 = 1'b1;
        repeat (3) @(negedge clk);
        fork
            begin
                for (int k = 0; k < 5; k++) begin
                    q1.push_back(mk1(6'(k * 9 + 1)));
                    send_char(1, mk1(6'(k * 9 + 1)));
                end
            end
            begin
                repeat (4) send_char(2, 7'h10);
                send_bit(2, 1); send_bit(2, 1);
                chk(l2 == 0, "R2 trk2 unlocked before start", l2, 0);
                send_char(2, 7'h0B);
                chk(l2 == 1, "R3 R9 trk2 locked on 0x0B", l2, 1);
                for (int k = 0; k < 6; k++) begin
                    q2.push_back(mk2(4'(k * 3 + 2)));
                    send_char(2, {2'b00, mk2(4'(k * 3 + 2))});
                end
            end
        join
        repeat (10) @(negedge clk);
        chk(q1.size() == 0, "R8 trk1 stream complete", q1.size(), 0);
        chk(q2.size() == 0, "R8 trk2 stream complete", q2.size(), 0);
        chk(sync2_cnt == 1, "R8 trk2 one sync", sync2_cnt, 1);
        chk(e2 == 0 && e1 == 0, "R8 no parity fault on clean streams", {e1, e2}, 0);
        finish_run();
    end
endmodule